// File: doc/BRIEF.md
# Pad Function Multiplexer with Low-Power Override

The block owns a small bank of 16-bit pad configuration words, one per pin, written and read over a simple register port. For each pin the stored word picks which of up to six functional sources drives the pad. It also sets the pad's pull resistor and enables the input path. When the pin's input path is enabled, the pad input is handed back to the selected source only. Every other source on that pin sees a constant tie-off value.

A global off-mode request is sampled on each clock. While it is active, every pin whose override bit is set takes its output enable, output value and pull settings from a second group of bits in its own word. The functional mux is set aside, and all function inputs on that pin are tied off. Configuration and pad state come up from power-on reset only. In that state, only the pins flagged as boot pins are attached to function 0. All other pins are parked with the output released and a pulldown enabled. The block raises no interrupt and no wake-up.

Top module: `padmux_ctrl`

## Requirements
- R1: After power-on reset, a boot pin (BOOT_PINS bit set, default pins 0 and 1) reads 16'h0100, which is mode 0 with input enabled. Every other pin reads 16'h000F, which is mode 7 with pulldown enabled. A parked pin drives pad_oe_n high.
- R2: When wr_en is high at a clock edge and wr_addr < NUM_PINS, the word at that index becomes wr_data masked with 16'h3F1F, and the pad outputs follow it right after that edge. Bit fields are: mode [2:0], pull enable [3], pull up (1) or down (0) [4], input enable [8], override enable [9], override output enable active low [10], override output value [11], override pull enable [12], override pull up [13]. All other bits read 0. rd_data returns the word at rd_addr combinationally.
- R3: Without override, a mode m in 0..5 drives pad_out and pad_oe_n of a pin from bit p*6+m of func_dout and func_oe_n.
- R4: Without override, modes 6 and 7 drive pad_oe_n = 1 and pad_out = 0, and tie all six function inputs of the pin to 0.
- R5: Without override, pad_pull_en follows bit 3 and pad_pull_up follows bit 4.
- R6: pad_ie follows bit 8. When bit 8 is 1, the mode is valid and there is no override, func_in bit p*6+mode carries pad_in[p]. Every other function input of the pin is 0.
- R7: When the sampled off mode is active and bit 9 is set, pad_oe_n = bit 10, pad_out = bit 11, pad_pull_en = bit 12 and pad_pull_up = bit 13. All function inputs of the pin are 0.
- R8: With bit 9 clear, off mode has no effect on the pin.
- R9: off_mode is registered. A change shows on the pads after the next rising clock edge and not before.
- R10: Writes with wr_addr >= NUM_PINS change no word. Reads with rd_addr >= NUM_PINS return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write pin index |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read pin index |
| rd_data | output | 16 | Read data |
| off_mode | input | 1 | Global low-power override request |
| func_dout | input | NUM_PINS*NUM_FUNCS | Output value from each source, pin-major |
| func_oe_n | input | NUM_PINS*NUM_FUNCS | Active-low output enable from each source |
| func_in | output | NUM_PINS*NUM_FUNCS | Pad input delivered to each source |
| pad_in | input | NUM_PINS | Input value seen at each pad |
| pad_out | output | NUM_PINS | Pad output value |
| pad_oe_n | output | NUM_PINS | Pad output enable, active low |
| pad_pull_en | output | NUM_PINS | Pull resistor enable |
| pad_pull_up | output | NUM_PINS | Pull direction, 1 up / 0 down |
| pad_ie | output | NUM_PINS | Pad input enable |

## Verification
A configuration write to a pin and a change of off_mode can land on the same clock edge. The pad state right after that edge must then reflect both the new word and the new override state at once. The stimulus holds bursts of writes to random pins, including out-of-range indices, and keeps toggling off_mode freely so that these collisions occur often. A behavioural model in the bench predicts every pad, function input and read value and compares them on each cycle, so a stale word or a stale off-mode sample shows up as a mismatch.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
    localparam int          CFG_W      = 16;
    localparam logic [15:0] CFG_MASK   = 16'h3F1F;
    localparam logic [15:0] CFG_BOOT   = 16'h0100;
    localparam logic [15:0] CFG_PARKED = 16'h000F;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic       off_pull_up;
        logic       off_pull_en;
        logic       off_out;
        logic       off_oe_n;
        logic       off_en;
        logic       ie;
        logic [2:0] rsv_mid;
        logic       pull_up;
        logic       pull_en;
        logic [2:0] mode;
    } pad_cfg_t;

    function automatic pad_cfg_t sanitize(input logic [CFG_W-1:0] raw);
        return pad_cfg_t'(raw & CFG_MASK);
    endfunction
endpackage

// File: rtl/padmux_regs.sv
module padmux_regs
    import padmux_pkg::*;
#(
    parameter int                 NUM_PINS  = 4,
    parameter int                 ADDR_W    = 4,
    parameter logic [NUM_PINS-1:0] BOOT_PINS = '1
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [CFG_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [CFG_W-1:0]             rd_data,
    input  logic                         off_mode_i,
    output logic                         off_q_o,
    output pad_cfg_t [NUM_PINS-1:0]      cfg_o
);
    localparam int IDX_W = $clog2(NUM_PINS);

    typedef struct packed {
        pad_cfg_t [NUM_PINS-1:0] cfg;
        logic                    off;
    } state_t;

    state_t st_d, st_q;
    logic   wr_hit;

    assign wr_hit = wr_en && (int'(wr_addr) < NUM_PINS);

    always_comb begin
        st_d     = st_q;
        st_d.off = off_mode_i;
        if (wr_hit) begin
            st_d.cfg[wr_addr[IDX_W-1:0]] = sanitize(wr_data);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                st_q.cfg[i] <= pad_cfg_t'(BOOT_PINS[i] ? CFG_BOOT : CFG_PARKED);
            end
            st_q.off <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < NUM_PINS) begin
            rd_data = CFG_W'(st_q.cfg[rd_addr[IDX_W-1:0]]);
        end
    end

    assign cfg_o   = st_q.cfg;
    assign off_q_o = st_q.off;

    // R2: an accepted write is visible in the stored word after the edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!por_n)
        wr_hit |=> (CFG_W'(cfg_o[$past(wr_addr[IDX_W-1:0])]) == ($past(wr_data) & CFG_MASK)));

    // R10: out-of-range writes leave every word untouched
    p_oob_write_ignored_r10: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && !wr_hit) |=> $stable(cfg_o));

    // R9: the override state follows the request one edge later
    p_off_sampled_r9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(off_mode_i) |=> off_q_o);
endmodule

// File: rtl/padmux_pin.sv
module padmux_pin
    import padmux_pkg::*;
#(
    parameter int   NUM_FUNCS = 6,
    parameter logic TIE_VAL   = 1'b0
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  pad_cfg_t             cfg_i,
    input  logic                 off_i,
    input  logic [NUM_FUNCS-1:0] func_dout_i,
    input  logic [NUM_FUNCS-1:0] func_oe_n_i,
    input  logic                 pad_in_i,
    output logic [NUM_FUNCS-1:0] func_in_o,
    output logic                 pad_out_o,
    output logic                 pad_oe_n_o,
    output logic                 pad_pull_en_o,
    output logic                 pad_pull_up_o,
    output logic                 pad_ie_o
);
    logic ovr_d;
    logic valid_d;

    always_comb begin
        ovr_d   = off_i && cfg_i.off_en;
        valid_d = int'(cfg_i.mode) < NUM_FUNCS;

        func_in_o = {NUM_FUNCS{TIE_VAL}};
        if (!ovr_d && valid_d && cfg_i.ie) begin
            func_in_o[cfg_i.mode] = pad_in_i;
        end

        if (ovr_d) begin
            pad_out_o     = cfg_i.off_out;
            pad_oe_n_o    = cfg_i.off_oe_n;
            pad_pull_en_o = cfg_i.off_pull_en;
            pad_pull_up_o = cfg_i.off_pull_up;
        end else begin
            pad_out_o     = valid_d ? func_dout_i[cfg_i.mode] : 1'b0;
            pad_oe_n_o    = valid_d ? func_oe_n_i[cfg_i.mode] : 1'b1;
            pad_pull_en_o = cfg_i.pull_en;
            pad_pull_up_o = cfg_i.pull_up;
        end
        pad_ie_o = cfg_i.ie;
    end

    // R4: an unused mode parks the pad with the driver released
    p_invalid_mode_parked_r4: assert property (@(posedge clk) disable iff (!por_n)
        (!(off_i && cfg_i.off_en) && cfg_i.mode >= 3'(NUM_FUNCS)) |-> (pad_oe_n_o && !pad_out_o));

    // R7: override takes pad state from the off bits
    p_override_r7: assert property (@(posedge clk) disable iff (!por_n)
        (off_i && cfg_i.off_en) |-> (pad_oe_n_o == cfg_i.off_oe_n && pad_pull_en_o == cfg_i.off_pull_en
                                     && func_in_o == {NUM_FUNCS{TIE_VAL}}));

    // R6: at most one source of the pin sees the pad
    p_input_single_r6: assert property (@(posedge clk) disable iff (!por_n)
        $countones(func_in_o ^ {NUM_FUNCS{TIE_VAL}}) <= 1);

    // R6: input disabled means every source sees the tie-off
    p_ie_gate_r6: assert property (@(posedge clk) disable iff (!por_n)
        !pad_ie_o |-> (func_in_o == {NUM_FUNCS{TIE_VAL}}));
endmodule

// File: rtl/padmux_ctrl.sv
module padmux_ctrl
    import padmux_pkg::*;
#(
    parameter int                  NUM_PINS  = 4,
    parameter int                  NUM_FUNCS = 6,
    parameter int                  ADDR_W    = 4,
    parameter logic [NUM_PINS-1:0] BOOT_PINS = 4'b0011
) (
    input  logic                            clk,
    input  logic                            por_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [15:0]                     wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [15:0]                     rd_data,
    input  logic                            off_mode,
    input  logic [NUM_PINS*NUM_FUNCS-1:0]   func_dout,
    input  logic [NUM_PINS*NUM_FUNCS-1:0]   func_oe_n,
    output logic [NUM_PINS*NUM_FUNCS-1:0]   func_in,
    input  logic [NUM_PINS-1:0]             pad_in,
    output logic [NUM_PINS-1:0]             pad_out,
    output logic [NUM_PINS-1:0]             pad_oe_n,
    output logic [NUM_PINS-1:0]             pad_pull_en,
    output logic [NUM_PINS-1:0]             pad_pull_up,
    output logic [NUM_PINS-1:0]             pad_ie
);
    pad_cfg_t [NUM_PINS-1:0] cfg_q;
    logic                    off_q;

    padmux_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .BOOT_PINS(BOOT_PINS)
    ) i_regs (
        .clk       (clk),
        .por_n     (por_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .off_mode_i(off_mode),
        .off_q_o   (off_q),
        .cfg_o     (cfg_q)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        padmux_pin #(
            .NUM_FUNCS(NUM_FUNCS),
            .TIE_VAL  (1'b0)
        ) i_pin (
            .clk          (clk),
            .por_n        (por_n),
            .cfg_i        (cfg_q[p]),
            .off_i        (off_q),
            .func_dout_i  (func_dout[p*NUM_FUNCS +: NUM_FUNCS]),
            .func_oe_n_i  (func_oe_n[p*NUM_FUNCS +: NUM_FUNCS]),
            .pad_in_i     (pad_in[p]),
            .func_in_o    (func_in[p*NUM_FUNCS +: NUM_FUNCS]),
            .pad_out_o    (pad_out[p]),
            .pad_oe_n_o   (pad_oe_n[p]),
            .pad_pull_en_o(pad_pull_en[p]),
            .pad_pull_up_o(pad_pull_up[p]),
            .pad_ie_o     (pad_ie[p])
        );
    end
endmodule

// File: tb/test_padmux_ctrl.sv
`timescale 1ns/1ps
module test_padmux_ctrl;
    localparam int NP = 4;
    localparam int NF = 6;
    localparam int AW = 4;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [15:0]     wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [15:0]     rd_data;
    logic            off_mode = 1'b0;
    logic [NP*NF-1:0] func_dout = '0;
    logic [NP*NF-1:0] func_oe_n = '0;
    logic [NP*NF-1:0] func_in;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out, pad_oe_n, pad_pull_en, pad_pull_up, pad_ie;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] cfg_m [NP];
    logic        off_m;

    always #2 clk = ~clk;

    padmux_ctrl i_padmux_ctrl (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .off_mode(off_mode),
        .func_dout(func_dout), .func_oe_n(func_oe_n), .func_in(func_in), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe_n(pad_oe_n), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .pad_ie(pad_ie)
    );

    // behavioural reference state
    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_m[0] <= 16'h0100; cfg_m[1] <= 16'h0100;
            cfg_m[2] <= 16'h000F; cfg_m[3] <= 16'h000F;
            off_m    <= 1'b0;
        end else begin
            off_m <= off_mode;
            if (wr_en && wr_addr < NP) cfg_m[wr_addr] <= wr_data & 16'h3F1F;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [NP-1:0]    e_out, e_oe, e_pe, e_pu, e_ie;
        logic [NP*NF-1:0] e_fin;
        e_fin = '0;
        for (int p = 0; p < NP; p++) begin
            logic [15:0] c;
            int m;
            bit ovr;
            c   = cfg_m[p];
            m   = int'(c[2:0]);
            ovr = off_m && c[9];
            e_ie[p] = c[8];
            if (ovr) begin
                e_oe[p] = c[10]; e_out[p] = c[11]; e_pe[p] = c[12]; e_pu[p] = c[13];
            end else begin
                e_pe[p] = c[3]; e_pu[p] = c[4];
                if (m < NF) begin
                    e_out[p] = func_dout[p*NF+m]; e_oe[p] = func_oe_n[p*NF+m];
                    if (c[8]) e_fin[p*NF+m] = pad_in[p];
                end else begin
                    e_out[p] = 1'b0; e_oe[p] = 1'b1;
                end
            end
        end
        chk("R3/R4/R7/R8/R9 pad_out", 32'(pad_out), 32'(e_out));
        chk("R3/R4/R7/R8/R9 pad_oe_n", 32'(pad_oe_n), 32'(e_oe));
        chk("R5/R7 pad_pull_en", 32'(pad_pull_en), 32'(e_pe));
        chk("R5/R7 pad_pull_up", 32'(pad_pull_up), 32'(e_pu));
        chk("R6 pad_ie", 32'(pad_ie), 32'(e_ie));
        chk("R6/R4 func_in", 32'(func_in), 32'(e_fin));
        chk("R2/R10 rd_data", 32'(rd_data), (rd_addr < NP) ? 32'(cfg_m[rd_addr]) : 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        // R1: reset contents and parked pads
        for (int a = 0; a < 6; a++) begin
            rd_addr = AW'(a);
            @(negedge clk);
            chk("R1 reset word", 32'(rd_data),
                (a < 2) ? 32'h0100 : (a < NP ? 32'h000F : 32'h0));
        end
        chk("R1 parked oe_n", 32'(pad_oe_n[3:2]), 32'h3);
        chk("R1 boot ie", 32'(pad_ie), 32'h3);

        // R9: off_mode not visible before the edge
        wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'h0E00; // override on, oe_n=1, out=1
        @(negedge clk);
        wr_en = 1'b0; off_mode = 1'b1;
        #1 chk("R9 before edge", 32'(pad_out[2]), 32'h0);
        @(negedge clk);
        chk("R9 after edge", 32'(pad_out[2]), 32'h1);
        chk("R7 override oe_n", 32'(pad_oe_n[2]), 32'h1);

        // R10: out-of-range write has no effect
        wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'hFFFF;
        @(negedge clk);
        wr_en = 1'b0;
        for (int a = 0; a < NP; a++) begin
            rd_addr = AW'(a);
            #1 chk("R10 words intact", 32'(rd_data), 32'(cfg_m[a]));
        end

        // R2 with simultaneous off_mode change: random traffic
        for (int cyc = 0; cyc < 4000; cyc++) begin
            compare_all();
            wr_en     = ($urandom % 3) == 0;
            wr_addr   = (($urandom % 5) == 4) ? AW'(4 + $urandom % 12) : AW'($urandom % NP);
            wr_data   = 16'($urandom);
            rd_addr   = AW'($urandom % 6);
            if (($urandom % 6) == 0) off_mode = ~off_mode;
            func_dout = (NP*NF)'($urandom);
            func_oe_n = (NP*NF)'($urandom);
            pad_in    = NP'($urandom);
            @(negedge clk);
        end
        compare_all();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule